// File: doc/BRIEF.md
# Parallel ROM Read Controller

This block lets a clocked host fetch single bytes from an asynchronous 128K x 8 read-only memory. That memory has an active-low chip-enable strobe and an active-low output-enable strobe. The host presents a 17-bit byte address with a valid/ready handshake. The controller registers the address onto the memory bus, lowers chip enable, and waits out the access time. It lowers output enable as late as the timing allows, samples the data bus at a fixed edge, and hands the byte back with a one-cycle valid pulse. After each capture it leaves output enable high for the float time before it accepts the next request. This stops the memory from driving the bus while another driver is enabled.

All waits are clock counts. The block computes them at elaboration from the clock period and a speed-grade parameter. Each limit is rounded up to whole cycles, and the address-to-data and OE-to-data limits get one extra cycle of margin for the sample edge. The output-float limit is rounded up only. Chip enable stays low between closely spaced requests. After a programmable run of idle cycles with no request, chip enable rises and the memory enters standby.

Top module: `rom_rd_ctrl`

## Requirements
- R1: While synchronous reset `rst` is high, and on the first cycle after it, `rom_ce_n` and `rom_oe_n` are 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the float wait ends. A request held during that time has no effect on `rom_addr`.
- R3: On the edge that accepts a request, `rom_addr` takes `req_addr` and `rom_ce_n` goes to 0. `rom_addr` then stays unchanged until the controller is idle again.
- R4: `rom_oe_n` falls OE_AT edges after the accepting edge. The counts are ACC = ceil(tACC/T)+1, OEC = ceil(tOE/T)+1 and OE_AT = max(ACC-OEC, 2). For speed grade 0/1/2, tACC is 70/90/120 ns and tOE is 30/35/35 ns. The defaults (T = 10 ns, grade 0) give OE_AT = 4.
- R5: `rom_data` is sampled on the edge CAP = OE_AT+OEC after acceptance (8 at the defaults). On that same edge `rom_oe_n` rises, `rsp_data` takes the sampled byte and `rsp_valid` goes high for exactly one cycle.
- R6: `rom_oe_n` is never 0 while `rom_ce_n` is 1.
- R7: After the capture edge, `rom_oe_n` stays 1 and `req_ready` stays 0 for FLT = max(ceil(tFLOAT/T),1) cycles. tFLOAT is 25/25/30 ns per grade, so FLT is 3 at the defaults. `req_ready` returns to 1 on edge CAP+FLT.
- R8: `rom_ce_n` stays 0 throughout a transfer and through idle gaps shorter than STBY cycles (default 4). Back-to-back requests therefore cycle only the address and `rom_oe_n`.
- R9: After STBY consecutive idle edges with no request, `rom_ce_n` rises on the STBY-th idle edge. It stays high until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host read request |
| req_addr | input | 17 | Byte address of the request |
| req_ready | output | 1 | Controller idle and able to take a request |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds a new byte |
| rsp_data | output | 8 | Last captured byte |
| rom_addr | output | 17 | Memory address bus |
| rom_ce_n | output | 1 | Memory chip enable, active low |
| rom_oe_n | output | 1 | Memory output enable, active low |
| rom_data | input | 8 | Memory data bus |

## Verification
Each timed result is counted from the accepting edge E0:
- the address and chip enable are due at E0;
- output enable falls at E4;
- the byte and its valid pulse arrive at E8;
- `req_ready` returns at E11;
- after that, chip enable rises on the fourth edge of an unbroken idle run.

The bench drives inputs on falling edges and compares every output at the falling edge after each rising edge. It does this for the whole window of a transfer, so a strobe or pulse that moves by one cycle fails the check for that cycle. The memory model in the bench returns the true byte only once the raw access and output-enable times in nanoseconds have elapsed, and returns the inverted byte before that.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_WAIT_OE,
        S_WAIT_DATA,
        S_CAPTURE,
        S_FLOAT
    } seq_state_e;

    // Whole cycles needed to cover a delay given in nanoseconds.
    function automatic int unsigned cyc_up(input int unsigned ns, input int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned t_acc_ns(input int unsigned grade);
        case (grade)
            0:       return 70;
            1:       return 90;
            default: return 120;
        endcase
    endfunction

    function automatic int unsigned t_oe_ns(input int unsigned grade);
        return (grade == 0) ? 30 : 35;
    endfunction

    function automatic int unsigned t_float_ns(input int unsigned grade);
        return (grade >= 2) ? 30 : 25;
    endfunction

endpackage

// File: rtl/rom_strobe_seq.sv
module rom_strobe_seq
    import rom_rd_pkg::*;
#(
    parameter int unsigned ADDR_W  = 17,
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned OE_AT   = 4,
    parameter int unsigned OE_CYC  = 4,
    parameter int unsigned FLT_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              standby_due,
    output logic              idle,
    output logic              cap_en,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n
);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              ce_n;
        logic              oe_n;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.st   = S_SETUP;
                    d.addr = req_addr;
                    d.ce_n = 1'b0;
                end else if (standby_due) begin
                    d.ce_n = 1'b1;
                end
            end
            S_SETUP: begin
                d.st  = S_WAIT_OE;
                d.cnt = CNT_W'(OE_AT - 2);
            end
            S_WAIT_OE: begin
                if (q.cnt == '0) begin
                    d.st   = S_WAIT_DATA;
                    d.oe_n = 1'b0;
                    d.cnt  = CNT_W'(OE_CYC - 2);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_WAIT_DATA: begin
                if (q.cnt == '0) d.st = S_CAPTURE;
                else             d.cnt = q.cnt - 1'b1;
            end
            S_CAPTURE: begin
                d.st   = S_FLOAT;
                d.oe_n = 1'b1;
                d.cnt  = CNT_W'(FLT_CYC - 1);
            end
            S_FLOAT: begin
                if (q.cnt == '0) d.st = S_IDLE;
                else             d.cnt = q.cnt - 1'b1;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st   <= S_IDLE;
            q.cnt  <= '0;
            q.addr <= '0;
            q.ce_n <= 1'b1;
            q.oe_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign idle     = (q.st == S_IDLE);
    assign cap_en   = (q.st == S_CAPTURE);
    assign rom_addr = q.addr;
    assign rom_ce_n = q.ce_n;
    assign rom_oe_n = q.oe_n;

endmodule

// File: rtl/rom_standby_timer.sv
module rom_standby_timer #(
    parameter int unsigned STBY_CYC = 4,
    parameter int unsigned TMR_W    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    input  logic clear,
    output logic due
);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    assign due = count_en && (q.cnt == TMR_W'(STBY_CYC - 1));

    always_comb begin
        d = q;
        if (clear || due)  d.cnt = '0;
        else if (count_en) d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) q.cnt <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/rom_byte_capture.sv
module rom_byte_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] rom_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } cap_t;

    cap_t q, d;

    always_comb begin
        d     = q;
        d.vld = cap_en;
        if (cap_en) d.dat = rom_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.vld <= 1'b0;
            q.dat <= '0;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.vld;
    assign rsp_data  = q.dat;

endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
    import rom_rd_pkg::*;
#(
    parameter int unsigned ADDR_W        = 17,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned SPEED_GRADE   = 0,
    parameter int unsigned STBY_CYC      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    input  logic [DATA_W-1:0] rom_data
);

    localparam int unsigned ACC_CYC = cyc_up(t_acc_ns(SPEED_GRADE), CLK_PERIOD_NS) + 1;
    localparam int unsigned OE_CYC  = cyc_up(t_oe_ns(SPEED_GRADE), CLK_PERIOD_NS) + 1;
    localparam int unsigned FLT_CYC = max2(cyc_up(t_float_ns(SPEED_GRADE), CLK_PERIOD_NS), 1);
    localparam int unsigned OE_AT   = max2(ACC_CYC - OE_CYC, 2);
    localparam int unsigned CNT_MAX = max2(OE_AT, max2(OE_CYC, FLT_CYC));
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam int unsigned TMR_W   = $clog2(STBY_CYC + 1);

    logic idle;
    logic cap_en;
    logic standby_due;
    logic tmr_count;
    logic tmr_clear;

    rom_strobe_seq #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .OE_AT  (OE_AT),
        .OE_CYC (OE_CYC),
        .FLT_CYC(FLT_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .standby_due(standby_due),
        .idle       (idle),
        .cap_en     (cap_en),
        .rom_addr   (rom_addr),
        .rom_ce_n   (rom_ce_n),
        .rom_oe_n   (rom_oe_n)
    );

    // Idle edges are counted only while the chip is selected and no request waits.
    assign tmr_count = idle && !rom_ce_n && !req_valid;
    assign tmr_clear = !idle;

    rom_standby_timer #(
        .STBY_CYC(STBY_CYC),
        .TMR_W   (TMR_W)
    ) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .count_en(tmr_count),
        .clear   (tmr_clear),
        .due     (standby_due)
    );

    rom_byte_capture #(
        .DATA_W(DATA_W)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .rom_data (rom_data),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data)
    );

    assign req_ready = idle;

endmodule

// File: rtl/rom_rd_chk.sv
module rom_rd_chk #(
    parameter int unsigned ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              rom_ce_n,
    input logic              rom_oe_n
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (rom_ce_n && rom_oe_n && !rsp_valid && req_ready)); // R1

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !$past(req_ready)) |-> $stable(rom_addr)); // R3

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R5

    AST_CAPTURE_ENDS_OE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $rose(rom_oe_n)); // R5

    AST_OE_UNDER_CE: assert property (@(posedge clk) disable iff (rst)
        !rom_oe_n |-> !rom_ce_n); // R6

    AST_IDLE_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> rom_oe_n); // R7

    AST_BUSY_SELECTED: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> !rom_ce_n); // R8

    AST_STANDBY_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(rom_ce_n) |-> req_ready); // R9

endmodule

bind rom_rd_ctrl rom_rd_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .rom_addr (rom_addr),
    .rom_ce_n (rom_ce_n),
    .rom_oe_n (rom_oe_n)
);

// File: tb/rom_rd_ctrl_test.sv
module rom_rd_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int STBY       = 4;
    localparam int T_ACC      = 70;
    localparam int T_OE       = 30;
    localparam int T_FLT      = 25;

    function automatic int up_div(input int ns);
        return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    endfunction

    localparam int ACC_B = up_div(T_ACC) + 1;
    localparam int OEC_B = up_div(T_OE) + 1;
    localparam int OEAT_B = (ACC_B - OEC_B > 2) ? ACC_B - OEC_B : 2;
    localparam int CAP_B = OEAT_B + OEC_B;
    localparam int FLT_B = (up_div(T_FLT) > 1) ? up_div(T_FLT) : 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [16:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic [16:0] rom_addr;
    logic        rom_ce_n;
    logic        rom_oe_n;
    logic [7:0]  rom_data = 8'h00;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    rom_rd_ctrl #(
        .CLK_PERIOD_NS(CLK_PERIOD),
        .SPEED_GRADE  (0),
        .STBY_CYC     (STBY)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_ready(req_ready),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data),
        .rom_addr (rom_addr),
        .rom_ce_n (rom_ce_n),
        .rom_oe_n (rom_oe_n),
        .rom_data (rom_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] romf(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'h69;
    endfunction

    // Memory model: the true byte appears only after the raw access and OE times.
    int          addr_t = 0;
    int          oe_t = 0;
    logic [16:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rom_ce_n || rom_addr != prev_addr) addr_t = cyc;
        if (rom_oe_n) oe_t = cyc;
        prev_addr = rom_addr;
        if (!rom_ce_n && !rom_oe_n &&
            (cyc + 1 - addr_t) * CLK_PERIOD >= T_ACC &&
            (cyc - oe_t) * CLK_PERIOD >= T_OE)
            rom_data = romf(rom_addr);
        else
            rom_data = ~romf(rom_addr);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Called at a falling edge with req_ready high; returns at the falling edge
    // after the edge on which ready comes back.
    task automatic rd(input logic [16:0] a, input bit noise);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        for (int k = 0; k <= CAP_B + FLT_B; k++) begin
            @(negedge clk);
            chk(rom_ce_n == 1'b0, "R8 ce low in transfer", rom_ce_n, 0);
            if (k < CAP_B + FLT_B)
                chk(rom_addr == a, "R3/R2 address held", rom_addr, a);
            chk(rom_oe_n == !(k >= OEAT_B && k < CAP_B), "R4 oe timing", rom_oe_n,
                !(k >= OEAT_B && k < CAP_B));
            chk(rsp_valid == (k == CAP_B), "R5 valid pulse", rsp_valid, k == CAP_B);
            if (k == CAP_B)
                chk(rsp_data == romf(a), "R5 captured byte", rsp_data, romf(a));
            if (k > CAP_B)
                chk(rsp_data == romf(a), "R7 data held in float", rsp_data, romf(a));
            chk(req_ready == (k >= CAP_B + FLT_B), "R7/R2 ready timing", req_ready,
                k >= CAP_B + FLT_B);
            if (noise && k < CAP_B + FLT_B - 1) begin
                req_valid = 1'b1;
                req_addr  = ~a;
            end else begin
                req_valid = 1'b0;
            end
        end
    endtask

    task automatic idle_wait(input int n);
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            chk(rom_ce_n == (j >= STBY), "R9/R8 standby timing", rom_ce_n, j >= STBY);
            chk(rom_oe_n == 1'b1, "R6 oe high idle", rom_oe_n, 1);
            chk(req_ready == 1'b1, "R2 ready idle", req_ready, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(rom_ce_n && rom_oe_n, "R1 strobes in reset", {rom_ce_n, rom_oe_n}, 3);
        chk(!rsp_valid && req_ready, "R1 handshake in reset", {rsp_valid, req_ready}, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(rom_ce_n && rom_oe_n && req_ready && !rsp_valid, "R1 after reset",
            {rom_ce_n, rom_oe_n, req_ready, rsp_valid}, 4'b1110);

        rd(17'h00000, 1'b0);
        idle_wait(STBY + 2);
        rd(17'h1FFFF, 1'b1);
        rd(17'h0ABCD, 1'b0);
        idle_wait(STBY - 1);
        rd(17'h10000, 1'b1);
        idle_wait(STBY);
        rd(17'h00001, 1'b0);

        for (int i = 0; i < 30; i++) begin
            idle_wait(int'($urandom % (STBY + 3)));
            rd(17'($urandom), 1'($urandom));
        end
        idle_wait(STBY + 1);
        finish_run();
    end

endmodule